// File: doc/BRIEF.md
# Receive Status and Error Substitution Stage

This stage sits on each receive lane of a PIPE-style PHY, between the 8b/10b decoder and elastic buffer on one side and the MAC on the other. Each cycle it takes one decoded byte with its control flag, a valid bit, and four error indications from upstream: invalid code, disparity error, elastic buffer overrun and elastic buffer underrun. It forwards the symbol to the MAC, applies lane polarity inversion when asked, and reports a 3-bit receive status code together with a strobe.

Each error class has its own fixed action on the stream. An invalid code is replaced by the EDB control symbol (K30.7, byte 8'hFE). An overrun drops the symbol. An underrun inserts an EDB. A disparity error leaves the symbol unchanged and only reports status. The status code always leaves the stage in the same cycle as the symbol it describes, or as the slot of the dropped symbol. When several errors arrive in one cycle, a fixed priority picks the single one that is reported. Every output is registered, so the latency from input to output is one cycle.

Top module: `pipe_rx_status`

## Requirements
- R1: While reset is high, and in the cycle after it, `out_valid`, `sts_valid` and `sts_code` are all zero.
- R2: A valid input with no error flag appears one cycle later with `out_valid`=1, the same K flag and the same data (before inversion), `sts_valid`=0 and `sts_code`=3'b000.
- R3: A valid input with `in_bad_code` set (and no buffer event) produces one cycle later `out_valid`=1, `out_k`=1, `out_data`=8'hFE, `sts_valid`=1 and `sts_code`=3'b100.
- R4: An input cycle with `eb_overrun` set produces one cycle later `out_valid`=0, `sts_valid`=1 and `sts_code`=3'b101, whatever `in_valid` is.
- R5: An input cycle with `eb_underrun` set and no overrun produces one cycle later an inserted EDB: `out_valid`=1, `out_k`=1, `out_data`=8'hFE, `sts_valid`=1 and `sts_code`=3'b110, whatever `in_valid` is.
- R6: A valid input with `in_disp_err` as its only flag passes through unchanged one cycle later, with `sts_valid`=1 and `sts_code`=3'b111.
- R7: When several flags are set together, only one is reported, with priority overrun, then underrun, then invalid code, then disparity error.
- R8: When `pol_inv` is high, a passed-through received byte is output bitwise inverted and its K flag is kept. A substituted or inserted EDB is never inverted.
- R9: An input cycle with `in_valid`=0 and no buffer event produces `out_valid`=0 and `sts_valid`=0 one cycle later. The invalid-code and disparity flags are ignored in that cycle.
- R10: `sts_valid` is 1 exactly when `sts_code` is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Receive clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Upstream symbol present |
| in_data | input | 8 | Decoded byte |
| in_k | input | 1 | Decoded byte is a control symbol |
| in_bad_code | input | 1 | Received 10-bit code was not valid |
| in_disp_err | input | 1 | Running disparity error on this symbol |
| eb_overrun | input | 1 | Elastic buffer overflowed; this symbol is dropped |
| eb_underrun | input | 1 | Elastic buffer empty; an EDB is inserted |
| pol_inv | input | 1 | Invert received data for this lane |
| out_valid | output | 1 | Symbol toward MAC is present |
| out_data | output | 8 | Byte toward MAC |
| out_k | output | 1 | Byte toward MAC is a control symbol |
| sts_valid | output | 1 | Receive status strobe |
| sts_code | output | 3 | Receive status code |

## Verification
The hardest case to reach is several error flags arriving together, combined with polarity inversion and with `in_valid` low. Only that mix shows whether the priority chain and the rule that EDB is never inverted hold. Uniform random flags rarely produce triple or quadruple coincidences. So the stimulus draws each flag with a modest probability to build up the ordinary mix, then runs a directed sweep of all 64 combinations of the four error flags, `in_valid` and `pol_inv`. An underrun with no upstream symbol and an overrun during an idle slot both come out of that sweep.

// File: rtl/pipe_rx_status_pkg.sv
package pipe_rx_status_pkg;

    localparam int SYM_W = 8;
    localparam int STS_W = 3;
    localparam logic [SYM_W-1:0] EDB_BYTE = 8'hFE;

    typedef enum logic [STS_W-1:0] {
        ST_OK      = 3'b000,
        ST_BADCODE = 3'b100,
        ST_OVER    = 3'b101,
        ST_UNDER   = 3'b110,
        ST_DISP    = 3'b111
    } rx_status_e;

    typedef enum logic [2:0] {
        ACT_IDLE,
        ACT_PASS,
        ACT_SUBST,
        ACT_DROP,
        ACT_INSERT
    } rx_action_e;

    typedef struct packed {
        logic             k;
        logic [SYM_W-1:0] data;
    } sym_t;

    typedef struct packed {
        rx_action_e act;
        rx_status_e sts;
    } verdict_t;

    typedef struct packed {
        logic       valid;
        sym_t       sym;
        logic       stb;
        rx_status_e sts;
    } out_word_t;

    // Highest priority first: overrun, underrun, invalid code, disparity.
    function automatic verdict_t judge(input logic valid, input logic bad,
                                       input logic disp, input logic over,
                                       input logic under);
        verdict_t v;
        if (over) begin
            v.act = ACT_DROP;   v.sts = ST_OVER;
        end else if (under) begin
            v.act = ACT_INSERT; v.sts = ST_UNDER;
        end else if (!valid) begin
            v.act = ACT_IDLE;   v.sts = ST_OK;
        end else if (bad) begin
            v.act = ACT_SUBST;  v.sts = ST_BADCODE;
        end else if (disp) begin
            v.act = ACT_PASS;   v.sts = ST_DISP;
        end else begin
            v.act = ACT_PASS;   v.sts = ST_OK;
        end
        return v;
    endfunction

    function automatic sym_t edb_sym();
        sym_t s;
        s.k    = 1'b1;
        s.data = EDB_BYTE;
        return s;
    endfunction

endpackage

// File: rtl/pipe_rx_status_classify.sv
module pipe_rx_status_classify
    import pipe_rx_status_pkg::*;
(
    input  logic     valid,
    input  logic     bad_code,
    input  logic     disp_err,
    input  logic     overrun,
    input  logic     underrun,
    output verdict_t verdict
);
    always_comb begin
        verdict = judge(valid, bad_code, disp_err, overrun, underrun);
    end
endmodule

// File: rtl/pipe_rx_status_shape.sv
module pipe_rx_status_shape
    import pipe_rx_status_pkg::*;
#(
    parameter bit INVERT_K = 1'b0
)(
    input  sym_t      sym_in,
    input  logic      invert,
    input  verdict_t  verdict,
    output out_word_t word
);
    sym_t rx_sym;

    // Polarity applies to received data only; K flag kept unless configured.
    generate
        if (INVERT_K) begin : g_inv_k
            assign rx_sym.k = sym_in.k ^ invert;
        end else begin : g_keep_k
            assign rx_sym.k = sym_in.k;
        end
    endgenerate
    assign rx_sym.data = invert ? ~sym_in.data : sym_in.data;

    always_comb begin
        word.valid = 1'b0;
        word.sym   = '0;
        word.sts   = verdict.sts;
        word.stb   = (verdict.sts != ST_OK);
        unique case (verdict.act)
            ACT_PASS: begin
                word.valid = 1'b1;
                word.sym   = rx_sym;
            end
            ACT_SUBST, ACT_INSERT: begin
                word.valid = 1'b1;
                word.sym   = edb_sym();
            end
            ACT_DROP, ACT_IDLE: begin
                word.valid = 1'b0;
                word.sym   = '0;
            end
            default: begin
                word.valid = 1'b0;
                word.sym   = '0;
            end
        endcase
    end
endmodule

// File: rtl/pipe_rx_status_oreg.sv
module pipe_rx_status_oreg
    import pipe_rx_status_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  out_word_t d,
    output out_word_t q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q.valid <= 1'b0;
            q.sym   <= '0;
            q.stb   <= 1'b0;
            q.sts   <= ST_OK;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/pipe_rx_status.sv
module pipe_rx_status
    import pipe_rx_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [SYM_W-1:0] in_data,
    input  logic             in_k,
    input  logic             in_bad_code,
    input  logic             in_disp_err,
    input  logic             eb_overrun,
    input  logic             eb_underrun,
    input  logic             pol_inv,
    output logic             out_valid,
    output logic [SYM_W-1:0] out_data,
    output logic             out_k,
    output logic             sts_valid,
    output logic [STS_W-1:0] sts_code
);
    verdict_t  verdict;
    sym_t      sym_in;
    out_word_t word_d;
    out_word_t word_q;

    assign sym_in.k    = in_k;
    assign sym_in.data = in_data;

    pipe_rx_status_classify u_classify (
        .valid    (in_valid),
        .bad_code (in_bad_code),
        .disp_err (in_disp_err),
        .overrun  (eb_overrun),
        .underrun (eb_underrun),
        .verdict  (verdict)
    );

    pipe_rx_status_shape #(.INVERT_K(1'b0)) u_shape (
        .sym_in  (sym_in),
        .invert  (pol_inv),
        .verdict (verdict),
        .word    (word_d)
    );

    pipe_rx_status_oreg u_oreg (
        .clk (clk),
        .rst (rst),
        .d   (word_d),
        .q   (word_q)
    );

    assign out_valid = word_q.valid;
    assign out_data  = word_q.sym.data;
    assign out_k     = word_q.sym.k;
    assign sts_valid = word_q.stb;
    assign sts_code  = word_q.sts;
endmodule

// File: rtl/pipe_rx_status_chk.sv
module pipe_rx_status_chk
    import pipe_rx_status_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             in_valid,
    input logic [SYM_W-1:0] in_data,
    input logic             in_k,
    input logic             in_bad_code,
    input logic             in_disp_err,
    input logic             eb_overrun,
    input logic             eb_underrun,
    input logic             pol_inv,
    input logic             out_valid,
    input logic [SYM_W-1:0] out_data,
    input logic             out_k,
    input logic             sts_valid,
    input logic [STS_W-1:0] sts_code
);
    logic prev_live;
    always_ff @(posedge clk) begin
        if (rst) prev_live <= 1'b0;
        else     prev_live <= 1'b1;
    end

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (!out_valid && !sts_valid && sts_code == 3'b000));

    assert_strobe_code_R10: assert property (@(posedge clk) disable iff (rst)
        prev_live |-> (sts_valid == (sts_code != 3'b000)));

    assert_overrun_drop_R4: assert property (@(posedge clk) disable iff (rst)
        (prev_live && $past(eb_overrun)) |->
        (!out_valid && sts_valid && sts_code == 3'b101));

    assert_underrun_insert_R5: assert property (@(posedge clk) disable iff (rst)
        (prev_live && $past(eb_underrun) && !$past(eb_overrun)) |->
        (out_valid && out_k && out_data == 8'hFE && sts_code == 3'b110));

    assert_badcode_edb_R3: assert property (@(posedge clk) disable iff (rst)
        (prev_live && $past(in_valid && in_bad_code && !eb_overrun && !eb_underrun)) |->
        (out_valid && out_k && out_data == 8'hFE && sts_code == 3'b100));

    assert_disp_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (prev_live && $past(in_valid && in_disp_err && !in_bad_code
                            && !eb_overrun && !eb_underrun)) |->
        (out_valid && out_k == $past(in_k) && sts_code == 3'b111));

    assert_polarity_R8: assert property (@(posedge clk) disable iff (rst)
        (prev_live && $past(in_valid && pol_inv && !in_bad_code
                            && !eb_overrun && !eb_underrun)) |->
        (out_data == ~$past(in_data)));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (prev_live && $past(!in_valid && !eb_overrun && !eb_underrun)) |->
        (!out_valid && !sts_valid));
endmodule

bind pipe_rx_status pipe_rx_status_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_k        (in_k),
    .in_bad_code (in_bad_code),
    .in_disp_err (in_disp_err),
    .eb_overrun  (eb_overrun),
    .eb_underrun (eb_underrun),
    .pol_inv     (pol_inv),
    .out_valid   (out_valid),
    .out_data    (out_data),
    .out_k       (out_k),
    .sts_valid   (sts_valid),
    .sts_code    (sts_code)
);

// File: tb/pipe_rx_status_test.sv
module pipe_rx_status_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_k = 1'b0;
    logic       in_bad_code = 1'b0;
    logic       in_disp_err = 1'b0;
    logic       eb_overrun = 1'b0;
    logic       eb_underrun = 1'b0;
    logic       pol_inv = 1'b0;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_k;
    logic       sts_valid;
    logic [2:0] sts_code;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pipe_rx_status uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data), .in_k(in_k),
        .in_bad_code(in_bad_code), .in_disp_err(in_disp_err),
        .eb_overrun(eb_overrun), .eb_underrun(eb_underrun), .pol_inv(pol_inv),
        .out_valid(out_valid), .out_data(out_data), .out_k(out_k),
        .sts_valid(sts_valid), .sts_code(sts_code)
    );

    // Expected {valid, k, data, strobe, code} from the requirements.
    function automatic logic [13:0] model(input logic v, input logic [7:0] d, input logic k,
                                          input logic bad, input logic disp,
                                          input logic ov, input logic un, input logic inv);
        if (ov)       return {1'b0, 1'b0, 8'h00, 1'b1, 3'b101};
        if (un)       return {1'b1, 1'b1, 8'hFE, 1'b1, 3'b110};
        if (!v)       return {1'b0, 1'b0, 8'h00, 1'b0, 3'b000};
        if (bad)      return {1'b1, 1'b1, 8'hFE, 1'b1, 3'b100};
        if (disp)     return {1'b1, k, inv ? ~d : d, 1'b1, 3'b111};
        return {1'b1, k, inv ? ~d : d, 1'b0, 3'b000};
    endfunction

    function automatic string tag_of(input logic v, input logic bad, input logic disp,
                                     input logic ov, input logic un, input logic inv);
        int n;
        n = int'(ov) + int'(un) + int'(bad && v) + int'(disp && v);
        if (n > 1)        return "R7";
        if (ov)           return "R4";
        if (un)           return "R5";
        if (!v)           return "R9";
        if (bad)          return "R3";
        if (disp)         return "R6";
        if (inv)          return "R8";
        return "R2";
    endfunction

    logic [13:0] exp_w;
    string       exp_tag;
    bit          pending = 1'b0;

    task automatic check_out();
        logic [13:0] act;
        tests++;
        act = {out_valid, out_k, out_data, sts_valid, sts_code};
        if (!exp_w[13]) begin
            act[12:4]   = 9'h0;
        end
        if (act != exp_w || (sts_valid != (sts_code != 3'b000))) begin
            fails++;
            $display("FAIL %s: got v=%b k=%b d=%h stb=%b code=%b, expected v=%b k=%b d=%h stb=%b code=%b (R10 tie)",
                     exp_tag, out_valid, out_k, out_data, sts_valid, sts_code,
                     exp_w[13], exp_w[12], exp_w[11:4], exp_w[3], exp_w[2:0]);
        end
    endtask

    // Drive at negedge; result appears after the next posedge, checked at the following negedge.
    task automatic step(input logic v, input logic [7:0] d, input logic k, input logic bad,
                        input logic disp, input logic ov, input logic un, input logic inv);
        @(negedge clk);
        if (pending) check_out();
        in_valid = v; in_data = d; in_k = k; in_bad_code = bad; in_disp_err = disp;
        eb_overrun = ov; eb_underrun = un; pol_inv = inv;
        exp_w   = model(v, d, k, bad, disp, ov, un, inv);
        exp_tag = tag_of(v, bad, disp, ov, un, inv);
        pending = 1'b1;
    endtask

    initial begin
        void'($urandom(32'd1729));
        // R1: reset with error flags active must still give idle outputs.
        in_valid = 1'b1; eb_underrun = 1'b1; in_bad_code = 1'b1;
        repeat (3) @(negedge clk);
        tests++;
        if (out_valid || sts_valid || sts_code != 3'b000) begin
            fails++;
            $display("FAIL R1: got v=%b stb=%b code=%b, expected 0 0 000",
                     out_valid, sts_valid, sts_code);
        end
        @(negedge clk);
        rst = 1'b0;
        eb_underrun = 1'b0; in_bad_code = 1'b0; in_valid = 1'b0;
        exp_w = 14'h0; exp_tag = "R1"; pending = 1'b1;

        // Directed corners.
        step(1, 8'h3C, 0, 0, 0, 0, 0, 0);   // R2
        step(1, 8'hBC, 1, 0, 0, 0, 0, 0);   // R2 control symbol
        step(1, 8'hA5, 0, 1, 0, 0, 0, 1);   // R3 and R8: EDB not inverted
        step(1, 8'h11, 0, 0, 0, 1, 0, 0);   // R4
        step(0, 8'h22, 0, 0, 0, 0, 1, 1);   // R5 insert with no symbol
        step(1, 8'h5A, 1, 0, 1, 0, 0, 1);   // R6 and R8
        step(1, 8'h77, 0, 1, 1, 1, 1, 0);   // R7 all flags
        step(0, 8'h66, 0, 1, 1, 0, 0, 0);   // R9 flags ignored while idle
        step(1, 8'h0F, 1, 0, 0, 0, 0, 1);   // R8 K kept

        // Sweep every flag combination.
        for (int c = 0; c < 64; c++) begin
            step(c[0], 8'(c * 37 + 5), c[1] ^ c[3], c[1], c[2], c[3], c[4], c[5]);
        end

        // Random mix.
        for (int i = 0; i < 2000; i++) begin
            step($urandom_range(0, 7) != 0, 8'($urandom), $urandom_range(0, 3) == 0,
                 $urandom_range(0, 7) == 0, $urandom_range(0, 7) == 0,
                 $urandom_range(0, 9) == 0, $urandom_range(0, 9) == 0,
                 $urandom_range(0, 1) == 1);
        end
        @(negedge clk);
        check_out();

        // R1 again: reset mid-stream.
        in_valid = 1'b1; eb_overrun = 1'b1; rst = 1'b1;
        @(negedge clk);
        tests++;
        if (out_valid || sts_valid || sts_code != 3'b000) begin
            fails++;
            $display("FAIL R1: got v=%b stb=%b code=%b, expected 0 0 000",
                     out_valid, sts_valid, sts_code);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule